// File: doc/BRIEF.md
# Per-Core Compare Timer Bank

This block sits beside one processor core and turns a shared 64-bit system count into four timer interrupts. The count comes in on a synchronous binary bus and is captured once per clock. Four compare slots watch it: a physical timer held in two independent copies (one for the secure world, one for the non-secure world), a virtual timer and a hypervisor physical timer. Each slot holds a 64-bit compare value, an enable bit and a mask bit. It reports a status bit and drives a level-sensitive interrupt line that stays high for as long as its condition holds.

The virtual slot does not compare the raw count. It compares the count minus a programmable 64-bit offset, so a guest can see a shifted time base. The physical and hypervisor slots use an offset of zero. Software reaches the slots through a single-cycle register port. The port carries a timer code, a field code and a secure flag, and that flag chooses which physical copy is touched.

Top module: `gtimer_bank`

## Requirements
- R1: The count bus is captured by a register on each rising clock edge. Status and interrupt outputs follow the captured value, so a change on the count bus is visible after the next edge and not before it.
- R2: Timer code 0 selects the physical timer. With the secure flag at 1 an access reaches only the secure copy, which drives interrupt bit 0. With the flag at 0 it reaches only the non-secure copy, which drives interrupt bit 1.
- R3: A slot's status is 1 exactly when its enable is 1 and (captured count − offset) ≥ compare value, compared unsigned. The offset is zero for both physical copies and for the hypervisor slot.
- R4: Timer code 1 selects the virtual slot, which drives interrupt bit 2. Its offset is written through field code 2, and the subtraction wraps modulo 2^64.
- R5: A slot's interrupt is its status AND NOT its mask, and it is level-sensitive: it stays high on every cycle while that condition holds. Masking does not clear the status bit.
- R6: A slot with enable at 0 has status 0 and interrupt 0, whatever its compare value and whatever the count.
- R7: Timer code 2 selects the hypervisor slot, which drives interrupt bit 3. Field code 0 is the compare value. Field code 1 is control: bit 0 is enable, bit 1 is mask, and bit 2 is the read-only status, which a write does not change.
- R8: Writes with timer code 3 or field code 3 change nothing, and reads of them return 0. An offset write (field 2) to any slot but the virtual one is also ignored, and such a read returns 0.
- R9: A synchronous active-low reset clears every compare value, enable, mask, the offset and the captured count, so all interrupts are low.
- R10: Read data is combinational from the access fields and the stored state. A write shows in read data after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 64 | System count, synchronous binary |
| acc_wr | input | 1 | Write strobe for the register port |
| acc_timer | input | 2 | Timer code: 0 physical, 1 virtual, 2 hypervisor, 3 unused |
| acc_field | input | 2 | Field code: 0 compare, 1 control, 2 offset, 3 unused |
| acc_secure | input | 1 | Chooses the physical copy: 1 secure, 0 non-secure |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data for the addressed field |
| irq_o | output | 4 | Level interrupts: bit0 secure phys, bit1 non-secure phys, bit2 virtual, bit3 hypervisor |

## Verification
The level-hold assertion assumes the count does not fall between two edges, measured in the slot's own offset frame, and assumes no write reaches that slot. The assertion checks both conditions itself, so a count that wraps or jumps back only exempts those cycles. The stimulus mostly moves the count forward by small steps and jumps it now and then, so the held-level case occurs often. The random compare values and offsets are drawn from a range near the count, so status changes in both directions. Directed cases cover the wrap of the virtual subtraction and the all-ones compare value.

// File: rtl/gtmr_pkg.sv
// gtmr_pkg: codes shared by the compare timer bank and its bench.
// Assumes four slots per core in a fixed order that sets the irq bit order.
package gtmr_pkg;

    localparam int NUM_SLOTS   = 4;
    localparam int SLOT_W      = 2;

    localparam int SLOT_SPHYS  = 0;
    localparam int SLOT_NSPHYS = 1;
    localparam int SLOT_VIRT   = 2;
    localparam int SLOT_HYP    = 3;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MASK_BIT = 1;
    localparam int CTL_STAT_BIT = 2;

    typedef enum logic [1:0] {
        TSEL_PHYS = 2'd0,
        TSEL_VIRT = 2'd1,
        TSEL_HYP  = 2'd2,
        TSEL_NONE = 2'd3
    } tsel_e;

    typedef enum logic [1:0] {
        FLD_CMP  = 2'd0,
        FLD_CTL  = 2'd1,
        FLD_OFS  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;

endpackage

// File: rtl/gtmr_decode.sv
// gtmr_decode: maps a register access onto one slot and produces per-slot
// write strobes. Assumes the access fields are stable while acc_wr is high.
module gtmr_decode
    import gtmr_pkg::*;
(
    input  logic                 wr_i,
    input  logic [1:0]           timer_i,
    input  logic [1:0]           field_i,
    input  logic                 secure_i,
    output logic [SLOT_W-1:0]    slot_o,
    output logic                 hit_o,
    output logic [NUM_SLOTS-1:0] wr_cmp_o,
    output logic [NUM_SLOTS-1:0] wr_ctl_o,
    output logic                 wr_ofs_o
);

    // purpose: pick the slot; the secure flag splits the physical timer
    always_comb begin
        hit_o  = 1'b1;
        slot_o = '0;
        unique case (tsel_e'(timer_i))
            TSEL_PHYS: slot_o = secure_i ? SLOT_W'(SLOT_SPHYS) : SLOT_W'(SLOT_NSPHYS);
            TSEL_VIRT: slot_o = SLOT_W'(SLOT_VIRT);
            TSEL_HYP:  slot_o = SLOT_W'(SLOT_HYP);
            default:   hit_o  = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_strobe
        // purpose: field strobes for slot g
        assign wr_cmp_o[g] = wr_i && hit_o && (slot_o == SLOT_W'(g)) && (fld_e'(field_i) == FLD_CMP);
        assign wr_ctl_o[g] = wr_i && hit_o && (slot_o == SLOT_W'(g)) && (fld_e'(field_i) == FLD_CTL);
    end

    // purpose: only the virtual slot owns an offset register
    assign wr_ofs_o = wr_i && hit_o && (slot_o == SLOT_W'(SLOT_VIRT)) && (fld_e'(field_i) == FLD_OFS);

endmodule

// File: rtl/gtmr_slot.sv
// gtmr_slot: one compare timer. Holds compare, enable and mask; derives
// status from the captured count less an offset (modulo 2^CNT_W) and
// drives a level interrupt. Assumes count and offset come from registers.
module gtmr_slot #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmp_i,
    input  logic             wr_ctl_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ofs_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             en_o,
    output logic             mask_o,
    output logic             status_o,
    output logic             irq_o
);
    import gtmr_pkg::*;

    logic [CNT_W-1:0] cmp_q;
    logic             en_q;
    logic             mask_q;
    logic [CNT_W-1:0] rel_cnt;

    // purpose: compare value register
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_q <= '0;
        else if (wr_cmp_i) cmp_q <= wdata_i;
    end

    // purpose: enable and mask bits; the status bit of a write is dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else if (wr_ctl_i) begin
            en_q   <= wdata_i[CTL_EN_BIT];
            mask_q <= wdata_i[CTL_MASK_BIT];
        end
    end

    // purpose: wrapping count in this slot's frame, then the condition
    assign rel_cnt  = cnt_i - ofs_i;
    assign status_o = en_q && (rel_cnt >= cmp_q);
    assign irq_o    = status_o && !mask_q;

    assign cmp_o  = cmp_q;
    assign en_o   = en_q;
    assign mask_o = mask_q;

    // R6: a write that clears enable silences the slot on the next cycle
    a_r6_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl_i && !wdata_i[CTL_EN_BIT] |=> !status_o && !irq_o);

    // R5: a write that sets the mask holds the line low on the next cycle
    a_r5_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl_i && wdata_i[CTL_MASK_BIT] |=> !irq_o);

endmodule

// File: rtl/gtimer_bank.sv
// gtimer_bank: four per-core compare timers on a shared 64-bit count.
// Slot 0/1 are the secure and non-secure physical copies, slot 2 the
// virtual timer (with offset), slot 3 the hypervisor physical timer.
// Assumes the count bus is synchronous to clk.
module gtimer_bank #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             acc_wr,
    input  logic [1:0]       acc_timer,
    input  logic [1:0]       acc_field,
    input  logic             acc_secure,
    input  logic [CNT_W-1:0] acc_wdata,
    output logic [CNT_W-1:0] acc_rdata,
    output logic [3:0]       irq_o
);
    import gtmr_pkg::*;

    logic [CNT_W-1:0]                cnt_q;
    logic [CNT_W-1:0]                ofs_q;
    logic [SLOT_W-1:0]               sel_slot;
    logic                            sel_hit;
    logic [NUM_SLOTS-1:0]            wr_cmp;
    logic [NUM_SLOTS-1:0]            wr_ctl;
    logic                            wr_ofs;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] cmp_all;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] ofs_all;
    logic [NUM_SLOTS-1:0]            en_all;
    logic [NUM_SLOTS-1:0]            mask_all;
    logic [NUM_SLOTS-1:0]            stat_all;
    logic [NUM_SLOTS-1:0]            irq_all;

    // purpose: capture the incoming count once per edge
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= count_i;
    end

    // purpose: virtual offset register
    always_ff @(posedge clk) begin
        if (!rst_n)      ofs_q <= '0;
        else if (wr_ofs) ofs_q <= acc_wdata;
    end

    gtmr_decode u_decode (
        .wr_i     (acc_wr),
        .timer_i  (acc_timer),
        .field_i  (acc_field),
        .secure_i (acc_secure),
        .slot_o   (sel_slot),
        .hit_o    (sel_hit),
        .wr_cmp_o (wr_cmp),
        .wr_ctl_o (wr_ctl),
        .wr_ofs_o (wr_ofs)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (g == SLOT_VIRT) begin : g_ofs
            assign ofs_all[g] = ofs_q;
        end else begin : g_zero
            assign ofs_all[g] = '0;
        end

        gtmr_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cmp_i (wr_cmp[g]),
            .wr_ctl_i (wr_ctl[g]),
            .wdata_i  (acc_wdata),
            .cnt_i    (cnt_q),
            .ofs_i    (ofs_all[g]),
            .cmp_o    (cmp_all[g]),
            .en_o     (en_all[g]),
            .mask_o   (mask_all[g]),
            .status_o (stat_all[g]),
            .irq_o    (irq_all[g])
        );

        // R5: with no write to the slot and a count that does not fall in
        // its frame, a raised line stays raised
        a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
            irq_all[g] && !wr_cmp[g] && !wr_ctl[g] && !wr_ofs &&
            ((count_i - ofs_all[g]) >= (cnt_q - ofs_all[g])) |=> irq_all[g]);
    end

    assign irq_o = irq_all;

    // purpose: combinational read of the addressed field
    always_comb begin
        acc_rdata = '0;
        if (sel_hit) begin
            unique case (fld_e'(acc_field))
                FLD_CMP: acc_rdata = cmp_all[sel_slot];
                FLD_CTL: begin
                    acc_rdata[CTL_EN_BIT]   = en_all[sel_slot];
                    acc_rdata[CTL_MASK_BIT] = mask_all[sel_slot];
                    acc_rdata[CTL_STAT_BIT] = stat_all[sel_slot];
                end
                FLD_OFS: acc_rdata = ofs_all[sel_slot];
                default: acc_rdata = '0;
            endcase
        end
    end

    // R2: a secure physical write leaves the non-secure copy untouched
    a_r2_secure_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && acc_timer == 2'd0 && acc_secure |=>
        $stable(cmp_all[SLOT_NSPHYS]) && $stable(en_all[SLOT_NSPHYS]) && $stable(mask_all[SLOT_NSPHYS]));

    // R2: a non-secure physical write leaves the secure copy untouched
    a_r2_nonsecure_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && acc_timer == 2'd0 && !acc_secure |=>
        $stable(cmp_all[SLOT_SPHYS]) && $stable(en_all[SLOT_SPHYS]) && $stable(mask_all[SLOT_SPHYS]));

    // R8: writes with the unused timer code change no stored state
    a_r8_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && (acc_timer == 2'd3 || acc_field == 2'd3) |=>
        $stable(cmp_all) && $stable(en_all) && $stable(mask_all) && $stable(ofs_q));

    // R4: the offset only moves on a virtual offset write
    a_r4_offset_owner: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && acc_timer == 2'd1 && acc_field == 2'd2) |=> $stable(ofs_q));

endmodule

// File: tb/tb_gtimer_bank.sv
// tb_gtimer_bank: directed corners plus seeded random traffic, checked
// against a bench model of the requirements.
module tb_gtimer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count_i = '0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_timer = '0;
    logic [1:0]  acc_field = '0;
    logic        acc_secure = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic [3:0]  irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] m_cmp [4];
    logic        m_en  [4];
    logic        m_mask[4];
    logic [63:0] m_ofs;
    logic [63:0] m_cnt;

    gtimer_bank dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .acc_wr(acc_wr),
        .acc_timer(acc_timer), .acc_field(acc_field), .acc_secure(acc_secure),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    function automatic int slot_of(logic [1:0] t, logic s);
        case (t)
            2'd0: return s ? 0 : 1;
            2'd1: return 2;
            2'd2: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic m_stat(int i);
        logic [63:0] o;
        o = (i == 2) ? m_ofs : 64'd0;
        return m_en[i] && ((m_cnt - o) >= m_cmp[i]);
    endfunction

    function automatic logic [3:0] m_irq();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = m_stat(i) && !m_mask[i];
        return r;
    endfunction

    function automatic logic [63:0] m_read(logic [1:0] t, logic [1:0] f, logic s);
        int i;
        i = slot_of(t, s);
        if (i < 0) return 64'd0;
        case (f)
            2'd0: return m_cmp[i];
            2'd1: return {61'd0, m_stat(i), m_mask[i], m_en[i]};
            2'd2: return (i == 2) ? m_ofs : 64'd0;
            default: return 64'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, model follows the edge, check irq after
    task automatic cyc(logic wr, logic [1:0] t, logic [1:0] f, logic s,
                       logic [63:0] d, logic [63:0] c, string req);
        int i;
        @(negedge clk);
        acc_wr = wr; acc_timer = t; acc_field = f; acc_secure = s;
        acc_wdata = d; count_i = c;
        @(posedge clk);
        if (wr) begin
            i = slot_of(t, s);
            if (i >= 0) begin
                if (f == 2'd0) m_cmp[i] = d;
                else if (f == 2'd1) begin m_en[i] = d[0]; m_mask[i] = d[1]; end
                else if (f == 2'd2 && i == 2) m_ofs = d;
            end
        end
        m_cnt = c;
        #2;
        chk({req, " irq"}, {60'd0, irq_o}, {60'd0, m_irq()});
    endtask

    task automatic wr(logic [1:0] t, logic [1:0] f, logic s, logic [63:0] d, string req);
        cyc(1'b1, t, f, s, d, count_i, req);
    endtask

    task automatic tick(logic [63:0] c, string req);
        cyc(1'b0, 2'd0, 2'd0, 1'b0, 64'd0, c, req);
    endtask

    task automatic rd(logic [1:0] t, logic [1:0] f, logic s, string req);
        @(negedge clk);
        acc_wr = 1'b0; acc_timer = t; acc_field = f; acc_secure = s;
        #1;
        chk({req, " read"}, acc_rdata, m_read(t, f, s));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_en[i] = 0; m_mask[i] = 0; end
        m_ofs = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R9: reset state
        chk("R9 irq after reset", {60'd0, irq_o}, 64'd0);
        rd(2'd0, 2'd0, 1'b1, "R9");
        rd(2'd1, 2'd2, 1'b0, "R9");
        rd(2'd2, 2'd1, 1'b0, "R9");

        // R2: two physical copies held apart
        wr(2'd0, 2'd0, 1'b1, 64'd100, "R2");
        wr(2'd0, 2'd0, 1'b0, 64'd200, "R2");
        rd(2'd0, 2'd0, 1'b1, "R2 secure copy");
        rd(2'd0, 2'd0, 1'b0, "R2 non-secure copy");
        wr(2'd0, 2'd1, 1'b1, 64'd1, "R2");
        wr(2'd0, 2'd1, 1'b0, 64'd1, "R2");
        // R3: thresholds
        tick(64'd99, "R3 below");
        tick(64'd100, "R3 equal");
        chk("R3 secure only", {60'd0, irq_o}, 64'd1);
        tick(64'd250, "R3 both");
        chk("R3 both high", {60'd0, irq_o}, 64'd3);
        // R1: count change not visible before the edge
        @(negedge clk); count_i = 64'd5; #1;
        chk("R1 before edge", {60'd0, irq_o}, 64'd3);
        tick(64'd5, "R1 after edge");
        chk("R1 after edge low", {60'd0, irq_o}, 64'd0);
        tick(64'd300, "R3");
        // R5: mask hides line, status read still 1; level holds
        wr(2'd0, 2'd1, 1'b1, 64'd3, "R5 mask");
        rd(2'd0, 2'd1, 1'b1, "R5 status under mask");
        chk("R5 masked low", {63'd0, irq_o[0]}, 64'd0);
        tick(64'd301, "R5 hold");
        tick(64'd302, "R5 hold");
        chk("R5 level held", {63'd0, irq_o[1]}, 64'd1);
        // R6: disable clears regardless of count
        wr(2'd0, 2'd1, 1'b0, 64'd2, "R6 disable");
        chk("R6 off", {63'd0, irq_o[1]}, 64'd0);
        rd(2'd0, 2'd1, 1'b0, "R6 status");

        // R4: virtual with offset
        wr(2'd1, 2'd2, 1'b0, 64'd10, "R4 offset");
        wr(2'd1, 2'd0, 1'b0, 64'd5, "R4 cmp");
        wr(2'd1, 2'd1, 1'b0, 64'd1, "R4 enable");
        tick(64'd14, "R4 below");
        chk("R4 below low", {63'd0, irq_o[2]}, 64'd0);
        tick(64'd15, "R4 equal");
        chk("R4 equal high", {63'd0, irq_o[2]}, 64'd1);
        wr(2'd1, 2'd2, 1'b0, 64'd100, "R4 offset");
        tick(64'd50, "R4 wrap");
        chk("R4 wrap high", {63'd0, irq_o[2]}, 64'd1);
        rd(2'd1, 2'd2, 1'b0, "R4 offset read");

        // R7: hypervisor slot at the all-ones corner; status bit write ignored
        wr(2'd2, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R7 cmp");
        wr(2'd2, 2'd1, 1'b0, 64'd5, "R7 ctl");
        tick(64'hFFFF_FFFF_FFFF_FFFE, "R7 below max");
        chk("R7 below max low", {63'd0, irq_o[3]}, 64'd0);
        rd(2'd2, 2'd1, 1'b0, "R7 status bit not writable");
        tick(64'hFFFF_FFFF_FFFF_FFFF, "R7 at max");
        chk("R7 at max high", {63'd0, irq_o[3]}, 64'd1);

        // R8: unused codes and stray offset writes
        wr(2'd3, 2'd0, 1'b0, 64'd7, "R8 timer3");
        wr(2'd3, 2'd1, 1'b1, 64'd0, "R8 timer3 ctl");
        wr(2'd2, 2'd3, 1'b0, 64'd0, "R8 field3");
        wr(2'd2, 2'd2, 1'b0, 64'd77, "R8 hyp offset");
        wr(2'd0, 2'd2, 1'b1, 64'd77, "R8 phys offset");
        rd(2'd3, 2'd0, 1'b0, "R8 timer3 read");
        rd(2'd2, 2'd2, 1'b0, "R8 hyp offset read");
        rd(2'd1, 2'd2, 1'b0, "R8 virt offset kept");
        rd(2'd2, 2'd0, 1'b0, "R8 hyp cmp kept");

        // R10 and all: seeded random traffic
        for (int n = 0; n < 600; n++) begin
            logic [63:0] c;
            logic [63:0] d;
            logic [1:0]  t;
            logic [1:0]  f;
            c = ($urandom % 16 == 0) ? 64'($urandom % 1024) : m_cnt + 64'($urandom % 6);
            if ($urandom % 3 == 0) begin
                t = 2'($urandom); f = 2'($urandom);
                d = (f == 2'd1) ? 64'($urandom % 4) :
                    (f == 2'd2 && $urandom % 4 == 0) ? {$urandom, $urandom} : 64'($urandom % 700);
                cyc(1'b1, t, f, 1'($urandom), d, c, "R10 random write");
            end else begin
                cyc(1'b0, 2'd0, 2'd0, 1'b0, 64'd0, c, "R3 random tick");
            end
            if ($urandom % 4 == 0) rd(2'($urandom), 2'($urandom), 1'($urandom), "R10 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule